// File: doc/BRIEF.md
# External Interrupt and Key-Wakeup Aggregator

This block watches eight external interrupt lines and keeps one latched request flag per line. Two of the lines also collect a bank of sixteen key-sense inputs and eight wakeup-event inputs. Each of those pins has a mask bit, and the pins act as a wired-AND collector onto the two highest lines. Every line has its own two-bit sense select and an enable bit. The flags can be read at any time, and software clears them by writing ones to a clear port.

All pin levels are taken without regard to the pin's data direction. Each merged line is resynchronised through two flops before edge or level detection. A flag is raised whenever its sense condition holds, whether or not the line is enabled. The enables only decide which pending flags reach the combined request. The combined request comes with a vector number equal to the vector base plus the index of the highest pending enabled line, and line 7 wins.

Top module: `extirq_aggregator`

## Requirements
- R1: While reset is held and right after it is released with all pins high, `flags` is 0, `irq_req` is 0 and `irq_vec` is 0.
- R2: The sense select of line n is `sense_sel[2n+1:2n]`. 00 sets the flag on every cycle the line is low. 01 sets it on a falling edge, 10 on a rising edge and 11 on either edge.
- R3: A change on a pin first shows in `flags` after the third rising clock edge that follows it: two synchroniser stages, then the flag register. It is not visible after the second edge.
- R4: A flag is set whatever its enable bit says. `irq_req` is high only while some flag n with `line_en[n]` = 1 is set.
- R5: With `clr_we` = 1, each 1 bit of `clr_data` clears the matching flag. Bits at 0 leave their flag alone, and `clr_data` has no effect while `clr_we` = 0. When a set condition and a clear hit the same flag in the same cycle, the flag stays set.
- R6: While `irq_req` is high, `irq_vec` is 16+n, where n is the highest-numbered line that is pending and enabled. While `irq_req` is low, `irq_vec` is 0.
- R7: Line 6 is low when its own pin is low, or when any key-sense input k in 0..7 is low with `key_mask[k]` = 0. A key input whose mask bit is 1 has no effect.
- R8: Line 7 is low when any key-sense input k in 8..15 with `key_mask[k]` = 0 is low, or when any wakeup input w with `wake_mask[w]` = 0 is low. Inputs whose mask bit is 1 have no effect.
- R9: The own pin of line 7 counts only while `key_mask[15:8]` and `wake_mask[7:0]` are all ones. If any of those bits is 0, the pin is ignored. The mask bits of keys 0..7 do not affect this gating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 8 | Dedicated interrupt line pins, bit n is line n |
| key_pin | input | 16 | Key-sense inputs |
| wake_pin | input | 8 | Wakeup-event inputs |
| key_mask | input | 16 | Per key input mask, 1 disables the input |
| wake_mask | input | 8 | Per wakeup input mask, 1 disables the input |
| sense_sel | input | 16 | Two-bit sense select per line |
| line_en | input | 8 | Per line request enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_data | input | 8 | Write-one-to-clear flag bits |
| flags | output | 8 | Latched request flags |
| irq_req | output | 1 | Combined request to the processor |
| irq_vec | output | 8 | Vector number of the winning line |

## Verification
On every cycle, the assertions check that the vector points at a pending enabled line with nothing enabled above it, and that the vector is zero when there is no request. They also check that no flag drops without a matching clear, and that a low-level line 0 held for the synchroniser depth ends up flagged. The bench scenarios cover the rest. These are the exact latency of each sense mode, set-over-clear in the same cycle, the wired-AND merging through the key and wakeup masks, and the gating of line 7's own pin by the upper masks. None of those can be seen from one cycle's port values.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   // Decide whether a line's sense condition is met this cycle.
   function automatic logic sense_hit(sense_e mode, logic prev, logic cur);
      case (mode)
         SENSE_LOW:  return ~cur;
         SENSE_FALL: return prev & ~cur;
         SENSE_RISE: return ~prev & cur;
         default:    return prev ^ cur;
      endcase
   endfunction

endpackage

// File: rtl/extirq_source_merge.sv
module extirq_source_merge #(
   parameter int NUM_LINES = 8,
   parameter int NUM_KEYS  = 16,
   parameter int NUM_WAKE  = 8
) (
   input  logic [NUM_LINES-1:0] irq_pin,
   input  logic [NUM_KEYS-1:0]  key_pin,
   input  logic [NUM_WAKE-1:0]  wake_pin,
   input  logic [NUM_KEYS-1:0]  key_mask,
   input  logic [NUM_WAKE-1:0]  wake_mask,
   output logic [NUM_LINES-1:0] line_raw
);
   localparam int HALF    = NUM_KEYS / 2;
   localparam int LINE_HI = NUM_LINES - 1;
   localparam int LINE_LO = NUM_LINES - 2;

   logic lo_group;
   logic hi_group;
   logic hi_pin_ok;

   // A masked pin reads as released (high) into the wired-AND.
   assign lo_group  = &(key_mask[HALF-1:0] | key_pin[HALF-1:0]);
   assign hi_group  = (&(key_mask[NUM_KEYS-1:HALF] | key_pin[NUM_KEYS-1:HALF]))
                    & (&(wake_mask | wake_pin));
   assign hi_pin_ok = (&key_mask[NUM_KEYS-1:HALF]) & (&wake_mask);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (i == LINE_HI) begin : g_hi
         assign line_raw[i] = (irq_pin[i] | ~hi_pin_ok) & hi_group;
      end else if (i == LINE_LO) begin : g_lo
         assign line_raw[i] = irq_pin[i] & lo_group;
      end else begin : g_plain
         assign line_raw[i] = irq_pin[i];
      end
   end

endmodule

// File: rtl/extirq_line.sv
module extirq_line
   import extirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_in,
   input  logic [1:0] sense,
   input  logic       clr,
   output logic       flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   hit;
   logic                   flag_q;

   assign cur = sync_q[SYNC_STAGES-1];
   assign hit = sense_hit(sense_e'(sense), prev_q, cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
         prev_q <= cur;
         flag_q <= hit | (flag_q & ~clr);
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/extirq_prio.sv
module extirq_prio #(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int VEC_BASE  = 16
) (
   input  logic [NUM_LINES-1:0] pending,
   output logic                 req,
   output logic [VEC_W-1:0]     vec
);
   always_comb begin
      req = |pending;
      vec = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (pending[i]) vec = VEC_W'(VEC_BASE + i);
      end
   end

endmodule

// File: rtl/extirq_aggregator.sv
module extirq_aggregator #(
   parameter int NUM_LINES   = 8,
   parameter int NUM_KEYS    = 16,
   parameter int NUM_WAKE    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:0]   irq_pin,
   input  logic [NUM_KEYS-1:0]    key_pin,
   input  logic [NUM_WAKE-1:0]    wake_pin,
   input  logic [NUM_KEYS-1:0]    key_mask,
   input  logic [NUM_WAKE-1:0]    wake_mask,
   input  logic [2*NUM_LINES-1:0] sense_sel,
   input  logic [NUM_LINES-1:0]   line_en,
   input  logic                   clr_we,
   input  logic [NUM_LINES-1:0]   clr_data,
   output logic [NUM_LINES-1:0]   flags,
   output logic                   irq_req,
   output logic [VEC_W-1:0]       irq_vec
);
   localparam int VEC_TOP = VEC_BASE + NUM_LINES - 1;

   if (NUM_LINES < 3) begin : g_bad_lines
      $error("NUM_LINES must be at least 3");
   end
   if (NUM_KEYS < 2 || (NUM_KEYS % 2) != 0) begin : g_bad_keys
      $error("NUM_KEYS must be even and at least 2");
   end
   if (NUM_WAKE < 1) begin : g_bad_wake
      $error("NUM_WAKE must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector range does not fit VEC_W");
   end

   logic [NUM_LINES-1:0] line_raw;
   logic [NUM_LINES-1:0] clr_mask;

   assign clr_mask = clr_we ? clr_data : '0;

   extirq_source_merge #(
      .NUM_LINES (NUM_LINES),
      .NUM_KEYS  (NUM_KEYS),
      .NUM_WAKE  (NUM_WAKE)
   ) u_merge (
      .irq_pin   (irq_pin),
      .key_pin   (key_pin),
      .wake_pin  (wake_pin),
      .key_mask  (key_mask),
      .wake_mask (wake_mask),
      .line_raw  (line_raw)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
      extirq_line #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_in (line_raw[n]),
         .sense   (sense_sel[2*n +: 2]),
         .clr     (clr_mask[n]),
         .flag    (flags[n])
      );
   end

   extirq_prio #(
      .NUM_LINES (NUM_LINES),
      .VEC_W     (VEC_W),
      .VEC_BASE  (VEC_BASE)
   ) u_prio (
      .pending (flags & line_en),
      .req     (irq_req),
      .vec     (irq_vec)
   );

endmodule

// File: rtl/extirq_checker.sv
module extirq_checker #(
   parameter int NUM_LINES   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pin0,
   input logic [1:0]           sense0,
   input logic [NUM_LINES-1:0] line_en,
   input logic                 clr_we,
   input logic [NUM_LINES-1:0] clr_data,
   input logic [NUM_LINES-1:0] flags,
   input logic                 irq_req,
   input logic [VEC_W-1:0]     irq_vec
);
   logic [NUM_LINES-1:0] clr_mask;
   logic [3:0]           since_rst;
   int                   hi_idx;
   logic                 sel_ok;
   logic                 above_clear;

   assign clr_mask = clr_we ? clr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != '1) since_rst <= since_rst + 4'd1;
   end

   always_comb begin
      hi_idx      = int'(irq_vec) - VEC_BASE;
      sel_ok      = 1'b0;
      above_clear = 1'b1;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (i == hi_idx) sel_ok = flags[i] & line_en[i];
         if (i > hi_idx && flags[i] && line_en[i]) above_clear = 1'b0;
      end
   end

   AST_VEC_POINTS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> sel_ok);                                              // R6
   AST_VEC_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> above_clear);                                         // R6
   AST_IDLE_NO_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == '0 && (flags & line_en) == '0));         // R4
   AST_FLAG_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flags) & ~$past(clr_mask)) & ~flags) == '0);     // R5
   AST_LOW_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(since_rst) > SYNC_STAGES + 1 && $past(pin0, SYNC_STAGES + 1) == 1'b0
       && $past(sense0) == 2'b00) |-> flags[0]);                        // R2

endmodule

bind extirq_aggregator extirq_checker #(
   .NUM_LINES   (NUM_LINES),
   .SYNC_STAGES (SYNC_STAGES),
   .VEC_W       (VEC_W),
   .VEC_BASE    (VEC_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin0     (irq_pin[0]),
   .sense0   (sense_sel[1:0]),
   .line_en  (line_en),
   .clr_we   (clr_we),
   .clr_data (clr_data),
   .flags    (flags),
   .irq_req  (irq_req),
   .irq_vec  (irq_vec)
);

// File: tb/sim_extirq_aggregator.sv
module sim_extirq_aggregator;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  ip;
   logic [15:0] kp;
   logic [7:0]  wp;
   logic [15:0] km;
   logic [7:0]  wm;
   logic [15:0] sense;
   logic [7:0]  en;
   logic        clr_we;
   logic [7:0]  clr_data;
   logic [7:0]  flags;
   logic        irq_req;
   logic [7:0]  irq_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   extirq_aggregator u0 (
      .clk(clk), .rst_n(rst_n), .irq_pin(ip), .key_pin(kp), .wake_pin(wp),
      .key_mask(km), .wake_mask(wm), .sense_sel(sense), .line_en(en),
      .clr_we(clr_we), .clr_data(clr_data), .flags(flags),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr_all();
      clr_we = 1'b1; clr_data = 8'hFF; step(1);
      clr_we = 1'b0; clr_data = 8'h00;
   endtask

   task automatic idle_pins();
      ip = 8'hFF; kp = 16'hFFFF; wp = 8'hFF; km = 16'hFFFF; wm = 8'hFF;
   endtask

   // Lines 6 and 7 on low level, lines 0..5 on falling edge with pins high.
   task automatic merge_case(input string tag, input logic [15:0] kmv, input logic [7:0] wmv,
                             input logic [15:0] kpv, input logic [7:0] wpv,
                             input logic [7:0] ipv, input logic [7:0] exp);
      idle_pins(); step(3); clr_all();
      km = kmv; wm = wmv; kp = kpv; wp = wpv; ip = ipv;
      step(3);
      check(tag, 32'(flags), 32'(exp));
   endtask

   initial begin
      rst_n = 1'b0; idle_pins(); sense = 16'h5555; en = 8'h00;
      clr_we = 1'b0; clr_data = 8'h00;
      step(3);
      check("R1 flags in reset", 32'(flags), 0);
      check("R1 req in reset", 32'(irq_req), 0);
      rst_n = 1'b1;
      step(4);
      check("R1 flags after reset", 32'(flags), 0);
      check("R1 req after reset", 32'(irq_req), 0);
      check("R1 vec after reset", 32'(irq_vec), 0);

      // Sense modes, latency, set-over-clear on plain lines 0..5.
      for (int L = 0; L < 6; L++) begin
         for (int m = 0; m < 4; m++) begin
            sense = 16'h5555; sense[2*L +: 2] = m[1:0]; ip = 8'hFF;
            step(3); clr_all(); step(1);
            check("R2 idle high", 32'(flags), 0);
            ip[L] = 1'b0;
            step(2);
            check("R3 not yet after two edges", 32'(flags[L]), 0);
            step(1);
            check("R2 R3 after falling", 32'(flags), (m != 2) ? (32'd1 << L) : 0);
            check("R4 disabled line gives no req", 32'(irq_req), 0);
            clr_we = 1'b1; clr_data = 8'hFF; step(1); clr_we = 1'b0; clr_data = 8'h00;
            check("R5 set wins over clear", 32'(flags[L]), (m == 0) ? 1 : 0);
            ip[L] = 1'b1;
            step(3);
            check("R2 after rising", 32'(flags[L]), (m == 0 || m >= 2) ? 1 : 0);
            clr_all();
            check("R5 write one clears", 32'(flags), 0);
         end
      end

      // Priority and enable sweep over every flag pattern.
      sense = 16'h5555; idle_pins(); step(3);
      for (int p = 0; p < 256; p++) begin
         clr_all();
         ip = ~8'(p);
         step(3);
         check("R2 pattern flags", 32'(flags), 32'(p));
         for (int e = 0; e < 4; e++) begin
            logic [7:0] ev;
            logic [7:0] mk;
            int         ex_vec;
            ev = (e == 0) ? 8'hFF : (e == 1) ? 8'h00 : (e == 2) ? 8'h55 : 8'(p * 7 + 3);
            en = ev;
            #1;
            mk = 8'(p) & ev;
            ex_vec = 0;
            for (int i = 0; i < 8; i++) if (mk[i]) ex_vec = 16 + i;
            check("R4 combined request", 32'(irq_req), (mk != 0) ? 1 : 0);
            check("R6 vector", 32'(irq_vec), 32'(ex_vec));
         end
         en = 8'h00;
         ip = 8'hFF;
         step(3);
      end

      // Clear port details.
      clr_all();
      ip = 8'h5A; step(3); ip = 8'hFF; step(3);
      check("R5 setup", 32'(flags), 32'h0A5);
      clr_we = 1'b1; clr_data = 8'h00; step(1);
      check("R5 zero bits keep", 32'(flags), 32'h0A5);
      clr_we = 1'b0; clr_data = 8'hFF; step(1);
      check("R5 no strobe keeps", 32'(flags), 32'h0A5);
      clr_we = 1'b1; clr_data = 8'h05; step(1); clr_we = 1'b0; clr_data = 8'h00;
      check("R5 partial clear", 32'(flags), 32'h0A0);

      // Key and wakeup merging.
      sense = 16'h0555;
      merge_case("R7 own pin of line 6", 16'hFFFF, 8'hFF, 16'hFFFF, 8'hFF, 8'hBF, 8'h40);
      for (int k = 0; k < 16; k++) begin
         for (int mb = 0; mb < 2; mb++) begin
            logic [15:0] kmv;
            logic [15:0] kpv;
            kmv = 16'hFFFF; kmv[k] = mb[0];
            kpv = 16'hFFFF; kpv[k] = 1'b0;
            merge_case((k < 8) ? "R7 key input" : "R8 key input", kmv, 8'hFF, kpv, 8'hFF,
                       8'hFF, (mb == 1) ? 8'h00 : ((k < 8) ? 8'h40 : 8'h80));
         end
      end
      for (int w = 0; w < 8; w++) begin
         for (int mb = 0; mb < 2; mb++) begin
            logic [7:0] wmv;
            logic [7:0] wpv;
            wmv = 8'hFF; wmv[w] = mb[0];
            wpv = 8'hFF; wpv[w] = 1'b0;
            merge_case("R8 wakeup input", 16'hFFFF, wmv, 16'hFFFF, wpv, 8'hFF,
                       (mb == 1) ? 8'h00 : 8'h80);
         end
      end
      merge_case("R9 line 7 pin accepted", 16'hFFFF, 8'hFF, 16'hFFFF, 8'hFF, 8'h7F, 8'h80);
      for (int b = 0; b < 24; b++) begin
         logic [15:0] kmv;
         logic [7:0]  wmv;
         kmv = 16'hFFFF; wmv = 8'hFF;
         if (b < 16) kmv[b] = 1'b0; else wmv[b-16] = 1'b0;
         merge_case("R9 line 7 pin gating", kmv, wmv, 16'hFFFF, 8'hFF, 8'h7F,
                    (b < 8) ? 8'h80 : 8'h00);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog R3 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule